// File: doc/BRIEF.md
# Programmable Local-Bus Chip-Select Timer

This block produces the active-low chip-select strobe that a host bridge drives onto its local bus during a read or write. A transfer begins when the initiator-ready input is seen high while the block is idle. Two clocks later comes the reference cycle, and every edge of the strobe is placed a programmed number of clocks after that reference. Reads and writes each have their own pair of 4-bit offsets, one for the falling edge and one for the rising edge. All four offsets live in one writable timing register.

The 2-bit index picks which of the four chip-select lines carries the strobe. The direction, the index and the bus style are all captured when the transfer is accepted. When the Motorola-type style is selected, the programmed offsets play no part. A fixed strobe, set by parameters, is used instead.

A transfer ends with a one-clock done pulse. After that the block returns to idle and can accept the next transfer.

State machine:
- States: `ST_IDLE`, `ST_WAIT_REF`, `ST_RUN` and `ST_DONE`.
- Transitions:
  - `ST_IDLE`→`ST_WAIT_REF` when initiator-ready is high.
  - `ST_WAIT_REF`→`ST_RUN` unconditionally.
  - `ST_RUN`→`ST_RUN` while the reference counter is below the end offset.
  - `ST_RUN`→`ST_DONE` when the counter equals the end offset.
  - `ST_DONE`→`ST_IDLE` unconditionally.

Top module: `cs_timer_top`

## Requirements
- R1: During and immediately after reset, all four chip-select lines are high and done is low.
- R2: The reference cycle is the second clock after the clock in which initiator-ready is accepted. An assert offset of 0 drives the strobe low in the reference cycle.
- R3: For a read, the read assert offset is taken from register bits 3:0 (A) and the read deassert offset from bits 7:4 (D). When D > A, the strobe is low from reference+A through reference+D-1 and high again at reference+D.
- R4: For a write, the write assert offset is taken from bits 11:8 and the write deassert offset from bits 15:12. The same timing rule as R3 applies.
- R5: When the deassert offset is less than or equal to the assert offset, the strobe is low for exactly one clock, at reference+A. This includes A=15 with D=0.
- R6: Only the line numbered by the index captured at acceptance (0 to 3) is driven low. At most one line is low in any cycle.
- R7: Done is high for exactly one clock. That clock is the one after the first clock in which the strobe is high again. All lines are high while done is high.
- R8: Initiator-ready is ignored while a transfer is in progress, including the done clock. Changes to direction, index and bus style during a transfer have no effect on it.
- R9: A register write made during a transfer, or in the clock the transfer is accepted, does not change that transfer. It applies from the next transfer on.
- R10: With the Motorola-type style selected (style input = 1), the register offsets are ignored. The strobe is low from reference+MOTO_ON through reference+MOTO_OFF-1; the defaults are 0 and 2.
- R11: The reset value of the register gives read 0/3 (read deassert 2 when PPORT_MODE=1) and write 0/3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_rdy | input | 1 | Initiator-ready; starts a transfer when the block is idle |
| is_write | input | 1 | 1 = write, 0 = read |
| cs_idx | input | 2 | Index of the chip-select line to drive |
| moto_style | input | 1 | 1 = Motorola-type style (fixed strobe), 0 = Intel-type |
| cfg_we | input | 1 | Timing register write enable |
| cfg_wdata | input | 32 | Timing register write data; bits 31:16 are not stored |
| cs_n | output | 4 | Active-low chip-select lines |
| xfer_done | output | 1 | One-clock transfer-done pulse |

## Verification
Let P0 be the clock edge that accepts initiator-ready, and let E be the effective end offset (D if D > A, otherwise A+1). The outputs seen after edge P(1+c) show reference clock c. The strobe is therefore expected low after edges P(1+A) through P(E), high after P(1+E), and done is expected after P(2+E). The bench computes A and E from its own copy of the register and checks both outputs at the falling clock edge after every edge from P0 to P(2+E). It then checks the idle clock that follows before starting the next transfer.

// File: rtl/cstm_pkg.sv
package cstm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_REF = 2'd1,
        ST_RUN      = 2'd2,
        ST_DONE     = 2'd3
    } cs_state_e;
endpackage

// File: rtl/cs_timing_regs.sv
module cs_timing_regs #(
    parameter int OFS_W      = 4,
    parameter int REG_W      = 32,
    parameter bit PPORT_MODE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [OFS_W-1:0] rd_on,
    output logic [OFS_W-1:0] rd_off,
    output logic [OFS_W-1:0] wr_on,
    output logic [OFS_W-1:0] wr_off
);
    localparam int NFIELD = 4;

    function automatic logic [OFS_W-1:0] field_rst(input int idx);
        case (idx)
            1:       return PPORT_MODE ? OFS_W'(2) : OFS_W'(3);
            3:       return OFS_W'(3);
            default: return '0;
        endcase
    endfunction

    logic [OFS_W-1:0] fld [NFIELD];

    for (genvar i = 0; i < NFIELD; i++) begin : g_fld
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      fld[i] <= field_rst(i);
            else if (cfg_we) fld[i] <= cfg_wdata[i*OFS_W +: OFS_W];
        end
    end

    assign rd_on  = fld[0];
    assign rd_off = fld[1];
    assign wr_on  = fld[2];
    assign wr_off = fld[3];
endmodule

// File: rtl/cs_edge_sel.sv
module cs_edge_sel #(
    parameter int OFS_W   = 4,
    parameter int CNT_W   = OFS_W + 1,
    parameter int MOTO_ON  = 0,
    parameter int MOTO_OFF = 2
) (
    input  logic             moto_style,
    input  logic             is_write,
    input  logic [OFS_W-1:0] rd_on,
    input  logic [OFS_W-1:0] rd_off,
    input  logic [OFS_W-1:0] wr_on,
    input  logic [OFS_W-1:0] wr_off,
    output logic [CNT_W-1:0] on_ofs,
    output logic [CNT_W-1:0] end_ofs
);
    logic [CNT_W-1:0] a_sel, d_sel;

    always_comb begin
        if (moto_style) begin
            a_sel = CNT_W'(MOTO_ON);
            d_sel = CNT_W'(MOTO_OFF);
        end else if (is_write) begin
            a_sel = CNT_W'(wr_on);
            d_sel = CNT_W'(wr_off);
        end else begin
            a_sel = CNT_W'(rd_on);
            d_sel = CNT_W'(rd_off);
        end
        on_ofs  = a_sel;
        end_ofs = (d_sel > a_sel) ? d_sel : a_sel + CNT_W'(1);
    end
endmodule

// File: rtl/cs_seq_fsm.sv
module cs_seq_fsm
    import cstm_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_rdy,
    input  logic [CNT_W-1:0] on_ofs,
    input  logic [CNT_W-1:0] end_ofs,
    output logic             accept,
    output logic             strobe,
    output logic             done,
    output cs_state_e        state
);
    cs_state_e        nxt;
    logic [CNT_W-1:0] cnt, on_q, end_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            on_q  <= '0;
            end_q <= '0;
        end else begin
            state <= nxt;
            if (accept) begin
                on_q  <= on_ofs;
                end_q <= end_ofs;
            end
            if (state == ST_RUN) cnt <= cnt + CNT_W'(1);
            else                 cnt <= '0;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (init_rdy) nxt = ST_WAIT_REF;
            ST_WAIT_REF: nxt = ST_RUN;
            ST_RUN:      if (cnt == end_q) nxt = ST_DONE;
            ST_DONE:     nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        accept = (state == ST_IDLE) && init_rdy;
        strobe = (state == ST_RUN) && (cnt >= on_q) && (cnt < end_q);
        done   = (state == ST_DONE);
    end
endmodule

// File: rtl/cs_timer_top.sv
module cs_timer_top
    import cstm_pkg::*;
#(
    parameter int NUM_CS     = 4,
    parameter int OFS_W      = 4,
    parameter int REG_W      = 32,
    parameter bit PPORT_MODE = 1'b0,
    parameter int MOTO_ON    = 0,
    parameter int MOTO_OFF   = 2,
    localparam int IDX_W     = $clog2(NUM_CS),
    localparam int CNT_W     = OFS_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_rdy,
    input  logic              is_write,
    input  logic [IDX_W-1:0]  cs_idx,
    input  logic              moto_style,
    input  logic              cfg_we,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [NUM_CS-1:0] cs_n,
    output logic              xfer_done
);
    logic [OFS_W-1:0] rd_on, rd_off, wr_on, wr_off;
    logic [CNT_W-1:0] on_ofs, end_ofs;
    logic             accept, strobe;
    logic [IDX_W-1:0] idx_q;
    cs_state_e        state;

    cs_timing_regs #(.OFS_W(OFS_W), .REG_W(REG_W), .PPORT_MODE(PPORT_MODE)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .rd_on(rd_on), .rd_off(rd_off), .wr_on(wr_on), .wr_off(wr_off)
    );

    cs_edge_sel #(.OFS_W(OFS_W), .CNT_W(CNT_W), .MOTO_ON(MOTO_ON), .MOTO_OFF(MOTO_OFF)) u_sel (
        .moto_style(moto_style), .is_write(is_write),
        .rd_on(rd_on), .rd_off(rd_off), .wr_on(wr_on), .wr_off(wr_off),
        .on_ofs(on_ofs), .end_ofs(end_ofs)
    );

    cs_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .init_rdy(init_rdy),
        .on_ofs(on_ofs), .end_ofs(end_ofs),
        .accept(accept), .strobe(strobe), .done(xfer_done), .state(state)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      idx_q <= '0;
        else if (accept) idx_q <= cs_idx;
    end

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign cs_n[i] = !(strobe && (idx_q == IDX_W'(i)));
    end
endmodule

// File: rtl/cs_timer_chk.sv
module cs_timer_chk
    import cstm_pkg::*;
#(
    parameter int NUM_CS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              init_rdy,
    input logic [NUM_CS-1:0] cs_n,
    input logic              done,
    input cs_state_e         state
);
    assert_onehot_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) <= 1);

    assert_same_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&cs_n) && !(&$past(cs_n))) |-> (cs_n == $past(cs_n)));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_lines_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((&cs_n) && (&$past(cs_n))));

    assert_ref_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && init_rdy) |=> (state == ST_WAIT_REF) ##1 (state == ST_RUN));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN) |-> ((&cs_n) && (state == ST_DONE || !done)));
endmodule

bind cs_timer_top cs_timer_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk(clk), .rst_n(rst_n), .init_rdy(init_rdy),
    .cs_n(cs_n), .done(xfer_done), .state(state)
);

// File: tb/tb_cs_timer_top.sv
module tb_cs_timer_top;
    localparam int MOTO_ON  = 0;
    localparam int MOTO_OFF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_rdy = 1'b0;
    logic        is_write = 1'b0;
    logic [1:0]  cs_idx = '0;
    logic        moto_style = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [3:0]  cs_n;
    logic        xfer_done;

    int          n_chk = 0;
    int          n_fail = 0;
    logic [15:0] shadow = 16'h3030;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    cs_timer_top #(.MOTO_ON(MOTO_ON), .MOTO_OFF(MOTO_OFF)) dut (
        .clk(clk), .rst_n(rst_n), .init_rdy(init_rdy), .is_write(is_write),
        .cs_idx(cs_idx), .moto_style(moto_style), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .cs_n(cs_n), .xfer_done(xfer_done)
    );

    function automatic int end_of(input int a, input int d);
        return (d > a) ? d : a + 1;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic cfg_write(input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = {$urandom, v};
        shadow = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic xfer(input bit wr, input logic [1:0] idx, input bit moto,
                        input bit scramble, input string tag);
        int a, d, e;
        logic [3:0] exp_cs;
        @(negedge clk);
        if (moto) begin
            a = MOTO_ON; d = MOTO_OFF;
        end else if (wr) begin
            a = int'(shadow[11:8]); d = int'(shadow[15:12]);
        end else begin
            a = int'(shadow[3:0]); d = int'(shadow[7:4]);
        end
        e = end_of(a, d);
        init_rdy = 1'b1; is_write = wr; cs_idx = idx; moto_style = moto;
        if (scramble && ($urandom % 2 == 0)) begin
            cfg_we = 1'b1; cfg_wdata = $urandom; shadow = cfg_wdata[15:0];
        end
        @(posedge clk);
        for (int j = 0; j <= e + 2; j++) begin
            if (j > 0) @(posedge clk);
            @(negedge clk);
            exp_cs = 4'hF;
            if (j >= 1 && (j - 1) >= a && (j - 1) < e) exp_cs[idx] = 1'b0;
            chk(cs_n == exp_cs, {tag, " R3 R4 R5 R6 R10 strobe"}, cs_n, exp_cs);
            chk(xfer_done == (j == e + 2), {tag, " R7 done"}, xfer_done, (j == e + 2));
            cfg_we = 1'b0;
            init_rdy = 1'b0;
            if (scramble) begin
                init_rdy = 1'($urandom);
                is_write = 1'($urandom);
                cs_idx = 2'($urandom);
                moto_style = 1'($urandom);
                if ($urandom % 4 == 0) begin
                    cfg_we = 1'b1; cfg_wdata = $urandom; shadow = cfg_wdata[15:0];
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0; init_rdy = 1'b0;
        chk(cs_n == 4'hF && !xfer_done, {tag, " R8 idle after done"}, {xfer_done, cs_n}, 4'hF);
    endtask

    initial begin
        for (int k = 0; k < 150000; k++) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(cs_n == 4'hF && !xfer_done, "R1 reset outputs", {xfer_done, cs_n}, 4'hF);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n == 4'hF && !xfer_done, "R1 after reset", {xfer_done, cs_n}, 4'hF);
        xfer(1'b0, 2'd0, 1'b0, 1'b0, "R11 R2 default read");
        xfer(1'b1, 2'd3, 1'b0, 1'b0, "R11 R4 default write");
        cfg_write(16'h9522);
        xfer(1'b0, 2'd1, 1'b0, 1'b0, "R5 equal offsets read");
        xfer(1'b1, 2'd2, 1'b0, 1'b0, "R4 programmed write");
        cfg_write(16'h0F0F);
        xfer(1'b0, 2'd2, 1'b1, 1'b0, "R10 moto read");
        xfer(1'b1, 2'd1, 1'b1, 1'b0, "R10 moto write");
        xfer(1'b0, 2'd3, 1'b0, 1'b0, "R5 max assert offset");
        cfg_write(16'hA371);
        xfer(1'b0, 2'd0, 1'b0, 1'b1, "R8 R9 scrambled read");
        for (int t = 0; t < 40; t++) begin
            xfer(1'($urandom), 2'($urandom), ($urandom % 5 == 0), 1'b1, "R9 random");
        end
        finish_run();
    end
endmodule